// File: doc/BRIEF.md
# Packed Fractional Multiply-Accumulate Unit

This block is the multiply datapath of a packed-arithmetic coprocessor. A 32-bit word holds two signed 16-bit lanes. Two signed lane multipliers work in parallel, and several post-processing modes follow them: plain widening multiply, multiply-accumulate into two 32-bit destinations, and multiply-add into a packed 16-bit destination. Two fractional modes handle Q15 data. The first returns the middle sixteen bits of each product. The second doubles each product, accumulates it and rounds the upper half. A single-lane mode picks one halfword from each multiplicand and accumulates the product into a full 32-bit word.

Each cycle the surrounding pipeline presents an operation code, an add/subtract code, a swizzle code, a lane-select code and four 32-bit words. The words are the multiplicand `src_b`, the multiplier `src_c`, and two accumulator sources `acc_a` and `acc_d`. One clock after a valid request, the unit returns up to two 32-bit results. A write enable flags each result that the operation produces. Register storage and instruction decode live outside the block.

Top module: `pfmac_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `res_a` and `res_d` are zero and `wen_a` and `wen_d` are low.
- R2: A request with `in_valid` high gives its write enables and results exactly one clock later. In a cycle after `in_valid` was low, both enables are low. Each result port keeps its value until an operation writes it again.
- R3: The swizzle code rearranges the halfwords of `src_b` into the (high, low) lane multiplicands. Code 0 keeps (upper, lower). Code 1 exchanges them to (lower, upper). Code 2 duplicates the upper half into both lanes. Code 3 duplicates the lower half into both lanes. `src_c` is never rearranged: its upper half feeds the high lane and its lower half feeds the low lane.
- R4: Operation 0, multiply: `res_a` is the 32-bit signed product of the high lane and `res_d` is that of the low lane. Both enables are set.
- R5: Operation 1, accumulate: `res_a = acc_a ± high product` and `res_d = acc_d ± low product`, modulo 2^32. Add/subtract bit 1 selects subtraction for the high lane and bit 0 for the low lane (AA=0, AS=1, SA=2, SS=3). Both enables are set.
- R6: Operation 2, packed multiply-add: each 16-bit lane of `res_d` is the matching lane of `acc_a` plus or minus the low 16 bits of that lane's product, modulo 2^16, using the R5 add/subtract bits. Only `wen_d` is set.
- R7: Operation 3, fractional multiply: `res_a` holds bits 30..15 of the high product in bits 31..16 and bits 30..15 of the low product in bits 15..0. -32768 × -32768 gives 0x8000 in that lane. Only `wen_a` is set.
- R8: Operation 4, rounded fractional accumulate. For the high lane, s = `acc_a` ± 2·product modulo 2^32; that lane's result is bits 31..16 of s + 0x8000, and it goes into `res_a[31:16]`. The low lane does the same with `acc_d` and goes into `res_a[15:0]`. The R5 add/subtract bits apply. Only `wen_a` is set.
- R9: Operation 5, single lane. Lane-select bit 1 picks the upper (1) or lower (0) half of `src_b`, and bit 0 does the same for `src_c`. Swizzle is ignored. `res_d = acc_a ± product` modulo 2^32, where add/subtract bit 1 selects subtraction. Only `wen_d` is set.
- R10: Operation codes 6 and 7 set neither enable and change neither result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| op | input | 3 | Operation code (R4–R10) |
| addsub | input | 2 | Per-lane subtract bits: bit 1 high lane, bit 0 low lane |
| swz | input | 2 | Multiplicand halfword arrangement |
| lane_sel | input | 2 | Halfword select for the single-lane mode |
| src_b | input | 32 | Multiplicand word |
| src_c | input | 32 | Multiplier word |
| acc_a | input | 32 | First accumulator source |
| acc_d | input | 32 | Second accumulator source |
| res_a | output | 32 | First result |
| wen_a | output | 1 | First result written this cycle |
| res_d | output | 32 | Second result |
| wen_d | output | 1 | Second result written this cycle |

## Verification
The bench builds the unit at its default lane width of 16. At that width the fractional bit positions and the rounding constant are the real ones, and the -32768 corner is reachable. It sweeps every operation code, add/subtract code, swizzle code and lane select. It crosses these with operand words built from a set of boundary halfwords: zero, one, the extremes, minus one and mixed-sign values. This set reaches the product that overflows the Q15 range and the modulo-2^32 accumulator wrap in every mode. Idle cycles and the unused operation codes are checked against result values held from earlier writes.

// File: rtl/pfmac_pkg.sv
package pfmac_pkg;

    localparam int LANE_W_DEF = 16;

    typedef enum logic [2:0] {
        OP_MUL     = 3'd0,
        OP_MAC     = 3'd1,
        OP_MADD    = 3'd2,
        OP_FRAC    = 3'd3,
        OP_FRACMAC = 3'd4,
        OP_SINGLE  = 3'd5,
        OP_RSVD6   = 3'd6,
        OP_RSVD7   = 3'd7
    } op_e;

    typedef struct packed {
        logic wr_a;
        logic wr_d;
    } wr_t;

    // Which destinations an operation produces.
    function automatic wr_t op_writes(op_e op);
        wr_t w;
        case (op)
            OP_MUL, OP_MAC:      w = '{wr_a: 1'b1, wr_d: 1'b1};
            OP_MADD, OP_SINGLE:  w = '{wr_a: 1'b0, wr_d: 1'b1};
            OP_FRAC, OP_FRACMAC: w = '{wr_a: 1'b1, wr_d: 1'b0};
            default:             w = '{wr_a: 1'b0, wr_d: 1'b0};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pfmac_swizzle.sv
module pfmac_swizzle #(
    parameter int LANE_W = pfmac_pkg::LANE_W_DEF
) (
    input  logic [2*LANE_W-1:0] word,
    input  logic [1:0]          code,
    output logic [LANE_W-1:0]   hi,
    output logic [LANE_W-1:0]   lo
);
    logic [LANE_W-1:0] up, dn;
    assign up = word[2*LANE_W-1:LANE_W];
    assign dn = word[LANE_W-1:0];

    always_comb begin
        case (code)
            2'd0:    begin hi = up; lo = dn; end
            2'd1:    begin hi = dn; lo = up; end
            2'd2:    begin hi = up; lo = up; end
            default: begin hi = dn; lo = dn; end
        endcase
    end
endmodule

// File: rtl/pfmac_mult.sv
module pfmac_mult #(
    parameter int LANE_W = pfmac_pkg::LANE_W_DEF
) (
    input  logic [LANE_W-1:0]   x,
    input  logic [LANE_W-1:0]   y,
    output logic [2*LANE_W-1:0] prod
);
    logic signed [2*LANE_W-1:0] xs, ys;
    assign xs   = $signed({{LANE_W{x[LANE_W-1]}}, x});
    assign ys   = $signed({{LANE_W{y[LANE_W-1]}}, y});
    assign prod = xs * ys;
endmodule

// File: rtl/pfmac_post.sv
module pfmac_post
    import pfmac_pkg::*;
#(
    parameter int LANE_W = pfmac_pkg::LANE_W_DEF
) (
    input  op_e                 op,
    input  logic [1:0]          addsub,
    input  logic [2*LANE_W-1:0] acc_a,
    input  logic [2*LANE_W-1:0] acc_d,
    input  logic [2*LANE_W-1:0] prod_hi,
    input  logic [2*LANE_W-1:0] prod_lo,
    output logic [2*LANE_W-1:0] nxt_a,
    output logic [2*LANE_W-1:0] nxt_d
);
    localparam int W  = LANE_W;
    localparam int WW = 2 * LANE_W;
    localparam logic [WW-1:0] RND = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

    logic [WW-1:0] sum_h, sum_l, dbl_h, dbl_l, fsum_h, fsum_l, frnd_h, frnd_l;
    logic [W-1:0]  madd_h, madd_l;

    always_comb begin
        sum_h  = addsub[1] ? acc_a - prod_hi : acc_a + prod_hi;
        sum_l  = addsub[0] ? acc_d - prod_lo : acc_d + prod_lo;
        dbl_h  = prod_hi << 1;
        dbl_l  = prod_lo << 1;
        fsum_h = addsub[1] ? acc_a - dbl_h : acc_a + dbl_h;
        fsum_l = addsub[0] ? acc_d - dbl_l : acc_d + dbl_l;
        frnd_h = fsum_h + RND;
        frnd_l = fsum_l + RND;
        madd_h = addsub[1] ? acc_a[WW-1:W] - prod_hi[W-1:0] : acc_a[WW-1:W] + prod_hi[W-1:0];
        madd_l = addsub[0] ? acc_a[W-1:0]  - prod_lo[W-1:0] : acc_a[W-1:0]  + prod_lo[W-1:0];

        nxt_a = '0;
        nxt_d = '0;
        case (op)
            OP_MUL:     begin nxt_a = prod_hi; nxt_d = prod_lo; end
            OP_MAC:     begin nxt_a = sum_h;   nxt_d = sum_l;   end
            OP_MADD:    nxt_d = {madd_h, madd_l};
            OP_FRAC:    nxt_a = {prod_hi[WW-2:W-1], prod_lo[WW-2:W-1]};
            OP_FRACMAC: nxt_a = {frnd_h[WW-1:W], frnd_l[WW-1:W]};
            OP_SINGLE:  nxt_d = sum_h;
            default:    ;
        endcase
    end
endmodule

// File: rtl/pfmac_unit.sv
module pfmac_unit
    import pfmac_pkg::*;
#(
    parameter int LANE_W = pfmac_pkg::LANE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic [1:0]          addsub,
    input  logic [1:0]          swz,
    input  logic [1:0]          lane_sel,
    input  logic [2*LANE_W-1:0] src_b,
    input  logic [2*LANE_W-1:0] src_c,
    input  logic [2*LANE_W-1:0] acc_a,
    input  logic [2*LANE_W-1:0] acc_d,
    output logic [2*LANE_W-1:0] res_a,
    output logic                wen_a,
    output logic [2*LANE_W-1:0] res_d,
    output logic                wen_d
);
    localparam int W  = LANE_W;
    localparam int WW = 2 * LANE_W;
    localparam int NLANE = 2;

    op_e op_q;
    assign op_q = op_e'(op);

    logic [W-1:0] sw_hi, sw_lo, pick_b, pick_c;
    logic [W-1:0] mx [NLANE];
    logic [W-1:0] my [NLANE];
    logic [WW-1:0] prod [NLANE];
    logic [WW-1:0] nxt_a, nxt_d;
    wr_t           wr;

    pfmac_swizzle #(.LANE_W(W)) u_swz (
        .word(src_b), .code(swz), .hi(sw_hi), .lo(sw_lo)
    );

    // Single-lane mode steers selected halves into the high multiplier.
    assign pick_b = lane_sel[1] ? src_b[WW-1:W] : src_b[W-1:0];
    assign pick_c = lane_sel[0] ? src_c[WW-1:W] : src_c[W-1:0];

    assign mx[1] = (op_q == OP_SINGLE) ? pick_b : sw_hi;
    assign my[1] = (op_q == OP_SINGLE) ? pick_c : src_c[WW-1:W];
    assign mx[0] = sw_lo;
    assign my[0] = src_c[W-1:0];

    for (genvar i = 0; i < NLANE; i++) begin : gen_lane
        pfmac_mult #(.LANE_W(W)) u_mult (
            .x(mx[i]), .y(my[i]), .prod(prod[i])
        );
    end

    pfmac_post #(.LANE_W(W)) u_post (
        .op(op_q), .addsub(addsub), .acc_a(acc_a), .acc_d(acc_d),
        .prod_hi(prod[1]), .prod_lo(prod[0]), .nxt_a(nxt_a), .nxt_d(nxt_d)
    );

    assign wr = op_writes(op_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_a <= '0;
            res_d <= '0;
            wen_a <= 1'b0;
            wen_d <= 1'b0;
        end else begin
            wen_a <= in_valid && wr.wr_a;
            wen_d <= in_valid && wr.wr_d;
            if (in_valid && wr.wr_a) res_a <= nxt_a;
            if (in_valid && wr.wr_d) res_d <= nxt_d;
        end
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !wen_a && !wen_d && $stable(res_a) && $stable(res_d));

    assert_mul_both_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0) |=> wen_a && wen_d);

    assert_mac_zero_mult_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd1 && src_c == '0) |=> res_a == $past(acc_a) && res_d == $past(acc_d));

    assert_madd_only_d_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 3'd2 || op == 3'd5)) |=> !wen_a && wen_d);

    assert_frac_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd3 && src_c == '0) |=> res_a == '0 && wen_a && !wen_d);

    assert_fracmac_only_a_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd4) |=> wen_a && !wen_d);

    assert_reserved_op_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2:1] == 2'b11) |=> !wen_a && !wen_d && $stable(res_a) && $stable(res_d));
endmodule

// File: tb/pfmac_unit_tb.sv
`timescale 1ns/1ps
module pfmac_unit_tb;
    localparam int LW = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [1:0]  addsub, swz, lane_sel;
    logic [31:0] src_b, src_c, acc_a, acc_d;
    logic [31:0] res_a, res_d;
    logic        wen_a, wen_d;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_a = '0, exp_d = '0;
    logic [15:0] vals [8];

    always #2 clk = ~clk;

    pfmac_unit #(.LANE_W(LW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .addsub(addsub),
        .swz(swz), .lane_sel(lane_sel), .src_b(src_b), .src_c(src_c),
        .acc_a(acc_a), .acc_d(acc_d), .res_a(res_a), .wen_a(wen_a),
        .res_d(res_d), .wen_d(wen_d)
    );

    task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic longint sx16(logic [15:0] v);
        return longint'($signed(v));
    endfunction

    // Drive one request at a negedge, check its results at the next negedge.
    task automatic apply(logic [2:0] o, logic [1:0] as, logic [1:0] sw, logic [1:0] sel,
                         logic [31:0] b, logic [31:0] c, logic [31:0] a, logic [31:0] d);
        logic [15:0] bh, bl, xs, ys;
        longint ph, pl, ps, t;
        logic [63:0] tv;
        logic [31:0] s32h, s32l;
        logic [15:0] mh, ml;
        logic ewa, ewd;
        string tag;
        case (sw)
            2'd0: begin bh = b[31:16]; bl = b[15:0];  end
            2'd1: begin bh = b[15:0];  bl = b[31:16]; end
            2'd2: begin bh = b[31:16]; bl = b[31:16]; end
            default: begin bh = b[15:0]; bl = b[15:0]; end
        endcase
        ph = sx16(bh) * sx16(c[31:16]);
        pl = sx16(bl) * sx16(c[15:0]);
        xs = sel[1] ? b[31:16] : b[15:0];
        ys = sel[0] ? c[31:16] : c[15:0];
        ps = sx16(xs) * sx16(ys);
        ewa = 1'b0; ewd = 1'b0;
        case (o)
            3'd0: begin tag = "R4_R3"; ewa = 1; ewd = 1;
                tv = 64'(ph); exp_a = tv[31:0]; tv = 64'(pl); exp_d = tv[31:0]; end
            3'd1: begin tag = "R5_R3"; ewa = 1; ewd = 1;
                t = as[1] ? longint'(a) - ph : longint'(a) + ph; tv = 64'(t); exp_a = tv[31:0];
                t = as[0] ? longint'(d) - pl : longint'(d) + pl; tv = 64'(t); exp_d = tv[31:0]; end
            3'd2: begin tag = "R6_R3"; ewd = 1;
                t = as[1] ? longint'(a[31:16]) - ph : longint'(a[31:16]) + ph; tv = 64'(t); mh = tv[15:0];
                t = as[0] ? longint'(a[15:0]) - pl : longint'(a[15:0]) + pl; tv = 64'(t); ml = tv[15:0];
                exp_d = {mh, ml}; end
            3'd3: begin tag = "R7_R3"; ewa = 1;
                tv = 64'(ph); mh = tv[30:15]; tv = 64'(pl); ml = tv[30:15];
                exp_a = {mh, ml}; end
            3'd4: begin tag = "R8_R3"; ewa = 1;
                t = as[1] ? longint'(a) - 2*ph : longint'(a) + 2*ph; tv = 64'(t); s32h = tv[31:0] + 32'h8000;
                t = as[0] ? longint'(d) - 2*pl : longint'(d) + 2*pl; tv = 64'(t); s32l = tv[31:0] + 32'h8000;
                exp_a = {s32h[31:16], s32l[31:16]}; end
            3'd5: begin tag = "R9"; ewd = 1;
                t = as[1] ? longint'(a) - ps : longint'(a) + ps; tv = 64'(t); exp_d = tv[31:0]; end
            default: tag = "R10";
        endcase
        in_valid = 1'b1; op = o; addsub = as; swz = sw; lane_sel = sel;
        src_b = b; src_c = c; acc_a = a; acc_d = d;
        @(negedge clk);
        in_valid = 1'b0;
        check32(tag, "wen_a", {31'd0, wen_a}, {31'd0, ewa});
        check32(tag, "wen_d", {31'd0, wen_d}, {31'd0, ewd});
        check32(tag, "res_a", res_a, exp_a);
        check32(tag, "res_d", res_d, exp_d);
    endtask

    initial begin
        #(150000 * 4);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
        vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'hC001; vals[7] = 16'h0100;
        rst = 1'b1; in_valid = 1'b0; op = '0; addsub = '0; swz = '0; lane_sel = '0;
        src_b = '0; src_c = '0; acc_a = '0; acc_d = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check32("R1", "res_a", res_a, 32'h0);
        check32("R1", "res_d", res_d, 32'h0);
        check32("R1", "wens", {30'd0, wen_a, wen_d}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check32("R1", "wens after release", {30'd0, wen_a, wen_d}, 32'h0);

        // R7/R8: most negative product, every fractional mode
        apply(3'd3, 2'd0, 2'd0, 2'd0, 32'h80008000, 32'h80008000, 32'h0, 32'h0);
        check32("R7", "frac -32768^2", res_a, 32'h80008000);
        apply(3'd4, 2'd0, 2'd0, 2'd0, 32'h80008000, 32'h80008000, 32'h0, 32'h0);
        check32("R8", "fracmac -32768^2", res_a, 32'h80008000);
        apply(3'd4, 2'd3, 2'd0, 2'd0, 32'h80008000, 32'h80008000, 32'h0, 32'h0);

        // R2: idle cycle after a write holds both results with enables low
        apply(3'd0, 2'd0, 2'd0, 2'd0, 32'h00030004, 32'h00050006, 32'h0, 32'h0);
        op = 3'd1; src_c = 32'hFFFFFFFF;
        @(negedge clk);
        check32("R2", "idle wens", {30'd0, wen_a, wen_d}, 32'h0);
        check32("R2", "idle res_a", res_a, 32'd15);
        check32("R2", "idle res_d", res_d, 32'd24);

        // Sweep all codes over boundary operand words (R3..R10)
        for (int o = 0; o < 8; o++)
            for (int as = 0; as < 4; as++)
                for (int k = 0; k < 16; k++)
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 8; j++)
                            apply(3'(o), 2'(as), 2'(k % 4), 2'(k / 4),
                                  {vals[i], vals[(i + 3) % 8]},
                                  {vals[j], vals[(j + 5) % 8]},
                                  {vals[(i + j) % 8], vals[(i + 6) % 8]},
                                  {vals[(j + 2) % 8], vals[(i + j + 1) % 8]});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule